// File: doc/BRIEF.md
# Software Pipelined Loop Branch Controller

This block resolves the loop-closing branch of a modulo-scheduled loop. It holds a loop counter, an epilogue counter, a 48-entry rotating predicate file and the rotating base that renames that file. Each branch strobe is one of two kinds. A counted branch is driven by the loop counter. A while branch is driven by a qualifying predicate supplied with the strobe. For each strobe the block decides whether the branch is taken or falls through, and it updates the counters. It then rotates the predicate file by one position and writes a stage predicate into the new logical slot 0. That predicate switches pipeline stages on while the prologue fills and the kernel runs, and switches them off while the epilogue drains.

Software first loads both counters, placing the stage count in the epilogue counter. After that, each loop branch is a single-cycle strobe. The outcome appears one cycle later, together with a phase indication (prologue, kernel, epilogue or done). A read port returns any logical predicate through the current rotation.

Top module: `swp_loop_ctrl`

## Requirements
- R1: After synchronous reset the loop counter, epilogue counter and rotating base are 0, every predicate reads 0, the phase is done (code 3) and no result is flagged.
- R2: A load sets the loop counter and epilogue counter from the load inputs, with no rotation and no result. It takes priority over a branch strobe in the same cycle. The phase becomes prologue (code 0), or kernel (code 1) when the loaded epilogue value is 0 or 1.
- R3: A counted branch (kind 0) with a nonzero loop counter is taken. It decrements the loop counter, leaves the epilogue counter unchanged and writes 1 into logical predicate 0.
- R4: A counted branch with the loop counter at 0 and the epilogue counter above 1 is taken. It decrements the epilogue counter and writes 0 into logical predicate 0.
- R5: A counted branch with the loop counter at 0 and the epilogue counter at 1 or 0 falls through. The epilogue counter becomes 0 and never wraps, and logical predicate 0 is written 0.
- R6: A while branch (kind 1) with the qualifying predicate at 1 is taken. It writes 1 into logical predicate 0 and leaves the epilogue counter unchanged. No while branch ever changes the loop counter.
- R7: A while branch with the qualifying predicate at 0 is taken and decrements the epilogue counter when that counter is above 1. Otherwise it falls through and leaves the epilogue counter at 0. Either way it writes 0 into logical predicate 0.
- R8: Every branch decrements the rotating base modulo 48, so 0 becomes 47. Logical predicate i reads physical entry (i + base) mod 48, so the value that was at logical k before a branch is found at logical k+1 after it.
- R9: The phase stays prologue until the count of stage-enabling branches since the load reaches the loaded epilogue value minus 1, and is kernel from then on. It is epilogue after a taken branch that writes 0, and done after a fall-through.
- R10: One cycle after each accepted strobe, the result-valid output is high for exactly one cycle, and the taken output carries the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load both counters |
| ld_lc | input | 16 | Loop counter load value |
| ld_ec | input | 6 | Epilogue counter load value (stage count) |
| br_go | input | 1 | Loop branch strobe |
| br_kind | input | 1 | 0 counted, 1 while |
| br_qp | input | 1 | Qualifying predicate for while branches |
| pred_idx | input | 6 | Logical predicate index to read (0..47) |
| pred_val | output | 1 | Logical predicate value at pred_idx |
| lc_out | output | 16 | Loop counter |
| ec_out | output | 6 | Epilogue counter |
| rrb_out | output | 6 | Rotating base |
| phase_out | output | 2 | 0 prologue, 1 kernel, 2 epilogue, 3 done |
| res_valid | output | 1 | Branch result strobe |
| res_taken | output | 1 | Branch taken |

## Verification
The bench follows the three-way split of counted loops: branches with a live loop counter, the drain with a zero loop counter, and the final fall-through. A design that tested only the loop counter would end the loop with no epilogue. A design that wrapped the epilogue counter below zero would turn a stray extra branch into a taken branch. The while runs check that the loop counter stays frozen and that the qualifying predicate alone keeps the kernel going. A run long enough to take the rotating base past 0 catches a base that wraps to 63 instead of 47. A load issued together with a strobe catches a design that lets the branch rotate or flag a result.

// File: rtl/swp_loop_pkg.sv
package swp_loop_pkg;

    typedef enum logic [1:0] {
        PH_PROLOGUE = 2'd0,
        PH_KERNEL   = 2'd1,
        PH_EPILOGUE = 2'd2,
        PH_DONE     = 2'd3
    } phase_e;

    typedef enum logic {
        BR_COUNTED = 1'b0,
        BR_WHILE   = 1'b1
    } br_kind_e;

    typedef struct packed {
        logic take;
        logic stage_val;
        logic lc_dec;
        logic ec_dec;
    } br_decision_t;

endpackage

// File: rtl/swp_loop_counters.sv
module swp_loop_counters
    import swp_loop_pkg::*;
#(
    parameter int LC_W = 16,
    parameter int EC_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld,
    input  logic [LC_W-1:0] lc_init,
    input  logic [EC_W-1:0] ec_init,
    input  logic            br_act,
    input  br_kind_e        kind,
    input  logic            qp,
    output logic [LC_W-1:0] lc,
    output logic [EC_W-1:0] ec,
    output br_decision_t    dec
);

    logic ec_gt1;
    logic ec_nz;
    logic keep_going;

    assign ec_gt1 = (ec > EC_W'(1));
    assign ec_nz  = (ec != '0);
    assign keep_going = (kind == BR_COUNTED) ? (lc != '0) : qp;

    always_comb begin
        dec = '0;
        if (keep_going) begin
            dec.take      = 1'b1;
            dec.stage_val = 1'b1;
            dec.lc_dec    = (kind == BR_COUNTED);
        end else if (ec_gt1) begin
            dec.take   = 1'b1;
            dec.ec_dec = 1'b1;
        end else begin
            dec.ec_dec = ec_nz;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lc <= '0;
            ec <= '0;
        end else if (ld) begin
            lc <= lc_init;
            ec <= ec_init;
        end else if (br_act) begin
            if (dec.lc_dec) lc <= lc - 1'b1;
            if (dec.ec_dec) ec <= ec - 1'b1;
        end
    end

    // R6
    while_lc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (br_act && kind == BR_WHILE) |=> $stable(lc));

    // R3
    counted_live_chk: assert property (@(posedge clk) disable iff (rst)
        (br_act && kind == BR_COUNTED && lc != '0) |=> (lc == $past(lc) - 1'b1) && $stable(ec));

    // R5
    ec_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (br_act && ec == '0) |=> (ec == '0));

endmodule

// File: rtl/swp_rot_pred.sv
module swp_rot_pred #(
    parameter int ROT_N = 48,
    localparam int IDX_W = $clog2(ROT_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rot_go,
    input  logic             stage_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] rrb,
    output logic             rd_val
);

    localparam logic [IDX_W:0]   N_EXT = (IDX_W+1)'(ROT_N);
    localparam logic [IDX_W-1:0] TOP   = IDX_W'(ROT_N - 1);

    logic [ROT_N-1:0] preds;
    logic [IDX_W-1:0] rrb_nx;
    logic [IDX_W:0]   sum;
    logic [IDX_W:0]   phys;

    assign rrb_nx = (rrb == '0) ? TOP : rrb - 1'b1;
    assign sum    = {1'b0, rd_idx} + {1'b0, rrb};
    assign phys   = (sum >= N_EXT) ? sum - N_EXT : sum;
    assign rd_val = preds[phys[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            rrb   <= '0;
            preds <= '0;
        end else if (rot_go) begin
            rrb           <= rrb_nx;
            preds[rrb_nx] <= stage_val;
        end
    end

    // R8
    rrb_range_chk: assert property (@(posedge clk) disable iff (rst)
        rrb < TOP + 1'b1);

    // R8
    rot_step_chk: assert property (@(posedge clk) disable iff (rst)
        rot_go |=> (($past(rrb) == '0) ? (rrb == TOP) : (rrb == $past(rrb) - 1'b1)));

    // R3
    new_slot_chk: assert property (@(posedge clk) disable iff (rst)
        rot_go |=> (preds[rrb] == $past(stage_val)));

endmodule

// File: rtl/swp_phase_track.sv
module swp_phase_track
    import swp_loop_pkg::*;
#(
    parameter int EC_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld,
    input  logic [EC_W-1:0] ec_init,
    input  logic            br_act,
    input  br_decision_t    dec,
    output phase_e          phase
);

    logic [EC_W-1:0] stages;
    logic [EC_W-1:0] fill;
    logic [EC_W-1:0] fill_nx;
    logic [EC_W:0]   fill_p1;

    assign fill_nx = (fill == '1) ? fill : fill + 1'b1;
    assign fill_p1 = {1'b0, fill_nx} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
            fill   <= '0;
            phase  <= PH_DONE;
        end else if (ld) begin
            stages <= ec_init;
            fill   <= '0;
            phase  <= (ec_init <= EC_W'(1)) ? PH_KERNEL : PH_PROLOGUE;
        end else if (br_act) begin
            if (!dec.take) begin
                phase <= PH_DONE;
            end else if (!dec.stage_val) begin
                phase <= PH_EPILOGUE;
            end else begin
                fill  <= fill_nx;
                phase <= (fill_p1 >= {1'b0, stages}) ? PH_KERNEL : PH_PROLOGUE;
            end
        end
    end

    // R9
    drain_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (br_act && dec.take && !dec.stage_val) |=> (phase == PH_EPILOGUE));

endmodule

// File: rtl/swp_loop_ctrl.sv
module swp_loop_ctrl
    import swp_loop_pkg::*;
#(
    parameter int LC_W  = 16,
    parameter int EC_W  = 6,
    parameter int ROT_N = 48,
    localparam int IDX_W = $clog2(ROT_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [LC_W-1:0]  ld_lc,
    input  logic [EC_W-1:0]  ld_ec,
    input  logic             br_go,
    input  logic             br_kind,
    input  logic             br_qp,
    input  logic [IDX_W-1:0] pred_idx,
    output logic             pred_val,
    output logic [LC_W-1:0]  lc_out,
    output logic [EC_W-1:0]  ec_out,
    output logic [IDX_W-1:0] rrb_out,
    output logic [1:0]       phase_out,
    output logic             res_valid,
    output logic             res_taken
);

    br_decision_t dec;
    br_kind_e     kind;
    phase_e       phase;
    logic         br_act;

    assign kind      = br_kind_e'(br_kind);
    assign br_act    = br_go & ~ld_en;
    assign phase_out = phase;

    swp_loop_counters #(.LC_W(LC_W), .EC_W(EC_W)) u_cnt (
        .clk(clk), .rst(rst), .ld(ld_en), .lc_init(ld_lc), .ec_init(ld_ec),
        .br_act(br_act), .kind(kind), .qp(br_qp),
        .lc(lc_out), .ec(ec_out), .dec(dec)
    );

    swp_rot_pred #(.ROT_N(ROT_N)) u_rot (
        .clk(clk), .rst(rst), .rot_go(br_act), .stage_val(dec.stage_val),
        .rd_idx(pred_idx), .rrb(rrb_out), .rd_val(pred_val)
    );

    swp_phase_track #(.EC_W(EC_W)) u_ph (
        .clk(clk), .rst(rst), .ld(ld_en), .ec_init(ld_ec),
        .br_act(br_act), .dec(dec), .phase(phase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_taken <= 1'b0;
        end else begin
            res_valid <= br_act;
            res_taken <= br_act & dec.take;
        end
    end

    // R5
    fall_ec_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_taken) |-> (ec_out == '0));

    // R9
    fall_done_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_taken) |-> (phase == PH_DONE));

    // R2
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (!res_valid && $stable(rrb_out)));

endmodule

// File: tb/tb_swp_loop_ctrl.sv
`timescale 1ns/1ps
module tb_swp_loop_ctrl;

    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [15:0] ld_lc = '0;
    logic [5:0]  ld_ec = '0;
    logic        br_go = 1'b0;
    logic        br_kind = 1'b0;
    logic        br_qp = 1'b0;
    logic [5:0]  pred_idx = '0;
    logic        pred_val;
    logic [15:0] lc_out;
    logic [5:0]  ec_out;
    logic [5:0]  rrb_out;
    logic [1:0]  phase_out;
    logic        res_valid;
    logic        res_taken;

    swp_loop_ctrl dut (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        int taken; int lc; int ec; int rrb; int ph; int p0; int p1; int p2;
    } exp_t;
    exp_t q[$];

    int errors = 0;
    int checks = 0;

    int m_lc = 0, m_ec = 0, m_rrb = 0, m_stages = 0, m_fill = 0, m_ph = 3;
    int m_pred[N];

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lp(int k);
        return m_pred[(k + m_rrb) % N];
    endfunction

    task automatic branch(input int kind, input int qp);
        exp_t e;
        int take, sv, live;
        live = (kind == 0) ? (m_lc != 0) : qp;
        if (live != 0) begin
            take = 1; sv = 1;
            if (kind == 0) m_lc--;
        end else if (m_ec > 1) begin
            take = 1; sv = 0; m_ec--;
        end else begin
            take = 0; sv = 0; if (m_ec > 0) m_ec--;
        end
        m_rrb = (m_rrb == 0) ? N - 1 : m_rrb - 1;
        m_pred[m_rrb] = sv;
        if (take == 0) m_ph = 3;
        else if (sv == 0) m_ph = 2;
        else begin
            if (m_fill < 63) m_fill++;
            m_ph = (m_fill + 1 >= m_stages) ? 1 : 0;
        end
        e.taken = take; e.lc = m_lc; e.ec = m_ec; e.rrb = m_rrb; e.ph = m_ph;
        e.p0 = lp(0); e.p1 = lp(1); e.p2 = lp(2);
        q.push_back(e);
        br_go = 1'b1; br_kind = kind[0]; br_qp = qp[0];
        @(negedge clk);
        br_go = 1'b0;
    endtask

    task automatic load(input int lc, input int ec, input bit with_br);
        int rrb_before;
        rrb_before = m_rrb;
        m_lc = lc; m_ec = ec; m_stages = ec; m_fill = 0;
        m_ph = (ec <= 1) ? 1 : 0;
        ld_en = 1'b1; ld_lc = lc[15:0]; ld_ec = ec[5:0];
        br_go = with_br; br_kind = 1'b0; br_qp = 1'b1;
        @(negedge clk);
        ld_en = 1'b0; br_go = 1'b0;
        chk("R2 load lc", int'(lc_out), lc);
        chk("R2 load ec", int'(ec_out), ec);
        chk("R2 load phase", int'(phase_out), m_ph);
        chk("R2 load no rotation", int'(rrb_out), rrb_before);
        @(negedge clk);
        chk("R2 load no result", int'(res_valid), 0);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            exp_t e;
            if (q.size() == 0) begin
                chk("R10 unexpected result", 1, 0);
            end else begin
                e = q.pop_front();
                chk("R10 taken", int'(res_taken), e.taken);
                chk("R3 R4 R5 lc", int'(lc_out), e.lc);
                chk("R4 R5 R7 ec", int'(ec_out), e.ec);
                chk("R8 rrb", int'(rrb_out), e.rrb);
                chk("R9 phase", int'(phase_out), e.ph);
                pred_idx = 6'd0; #0.2;
                chk("R3 R4 R6 R7 logical pred0", int'(pred_val), e.p0);
                pred_idx = 6'd1; #0.2;
                chk("R8 logical pred1", int'(pred_val), e.p1);
                pred_idx = 6'd2; #0.2;
                chk("R8 logical pred2", int'(pred_val), e.p2);
            end
        end
    end

    bit finished = 1'b0;

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_pred[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 lc", int'(lc_out), 0);
        chk("R1 ec", int'(ec_out), 0);
        chk("R1 rrb", int'(rrb_out), 0);
        chk("R1 phase", int'(phase_out), 3);
        chk("R1 valid", int'(res_valid), 0);
        for (int k = 0; k < N; k += 7) begin
            pred_idx = k[5:0]; #0.2;
            chk("R1 pred", int'(pred_val), 0);
        end
        @(negedge clk);

        // counted loop: 3 stages, 4 iterations (R3 R4 R5 R9)
        load(3, 3, 1'b0);
        for (int i = 0; i < 4; i++) branch(0, 0);
        branch(0, 0);
        branch(0, 0);
        branch(0, 0);   // extra branch at ec 0: saturate (R5)
        repeat (2) @(negedge clk);

        // while loop: lc frozen (R6 R7)
        load(5, 2, 1'b0);
        branch(1, 1);
        branch(1, 1);
        branch(1, 1);
        branch(1, 0);
        branch(1, 0);
        repeat (2) @(negedge clk);
        chk("R6 lc frozen", int'(lc_out), 5);

        // load wins over simultaneous strobe (R2); single stage starts in kernel
        load(2, 1, 1'b1);
        branch(0, 0);
        branch(0, 0);
        branch(0, 0);
        repeat (2) @(negedge clk);

        // long while run wraps the rotating base (R8)
        load(0, 4, 1'b0);
        for (int i = 0; i < 50; i++) branch(1, 1);
        branch(1, 0);
        branch(1, 0);
        branch(1, 0);
        branch(1, 0);
        repeat (3) @(negedge clk);
        chk("R10 queue drained", q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule